// File: doc/BRIEF.md
# Six-Channel Clipping Stereo Mixer

This block is the final per-sample stage of a six-voice FM synthesizer. Each sample period the voice engine presents six signed channel results on a one-cycle valid strobe. The mixer saturates every channel on its own to a 14-bit signed range. It then gates each channel into a left bus and a right bus according to that channel's pan bits, and adds the gated values into two 17-bit accumulators. The stereo pair is registered and marked by an output-valid pulse one clock after the input strobe.

The last channel can be handed over to a direct sample path. When the direct-sample mode is on, an unsigned 8-bit byte replaces the sixth channel's FM result. The byte is first recentred to signed by subtracting 128 and scaled by 64. The pan masks and the mode flag are loaded together by one configuration strobe. The byte is loaded by its own strobe. Both take effect for samples that arrive after the write.

Saturation happens per channel only. The two sums are never limited, so a loud mix can exceed the 14-bit range of any single channel.

Top module: `fm_stereo_mixer`

## Requirements
- R1: A channel input above +8191 enters the mix as +8191, and one below -8192 enters as -8192.
- R2: A channel input within -8192..+8191 enters the mix unchanged.
- R3: Channel i (bit i of a pan mask, bit 0 = first channel) adds nothing to a side whose pan bit is 0. With an all-zero left mask, out_l is 0.
- R4: out_l is the sum of the clipped values of all channels whose left bit is 1, and out_r is the same for the right bits.
- R5: The sums are not limited. Six channels at +8191 give +49146, and six at -8192 give -49152.
- R6: While the direct-sample mode is on, channel 5 contributes (byte - 128) * 64 in place of its input, and the channel 5 input has no effect. Byte 0xFF gives +8128, 0x00 gives -8192 and 0x80 gives 0. Turning the mode off restores the channel 5 input.
- R7: After reset both pan masks are all ones, the direct-sample mode is off, the stored direct sample is 0, out_valid is 0 and both outputs are 0.
- R8: out_valid is 1 exactly in the cycle after a cycle with in_valid = 1. Between samples, out_l and out_r hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe: channel inputs are sampled |
| ch_sum | input | 108 | Six 18-bit signed channel values, channel i at bits [18*i+17 : 18*i] |
| cfg_we | input | 1 | Loads both pan masks and the direct-sample mode flag |
| cfg_pan_l | input | 6 | Left enable per channel (bit i = channel i) |
| cfg_pan_r | input | 6 | Right enable per channel (bit i = channel i) |
| cfg_dac_en | input | 1 | Direct-sample mode flag: 1 replaces channel 5 |
| dac_we | input | 1 | Loads the direct-sample byte |
| dac_byte | input | 8 | Unsigned direct-sample byte, 0x80 = silence |
| out_valid | output | 1 | Pulses one cycle after in_valid |
| out_l | output | 17 | Signed left sum |
| out_r | output | 17 | Signed right sum |

## Verification
The only state in the block is the configuration and the output register. A wrong pan or mode bit therefore shows up in the first sample after it goes wrong, as a sum off by exactly one channel's contribution. A saturation fault only appears when a channel is driven past the 14-bit range, so the vectors push channels just past each limit and far past them, in single-channel and all-channel mixes. The reset values are checked both at power-up and after a reset that follows a non-default configuration. A stuck or stale output register shows as a missing out_valid pulse, or as an out_l value that moves between samples.

// File: rtl/mix_pkg.sv
`timescale 1ns/1ps
package mix_pkg;
    localparam int NCH       = 6;
    localparam int IN_W      = 18;
    localparam int CLIP_W    = 14;
    localparam int DAC_W     = 8;
    localparam int DAC_SHIFT = CLIP_W - DAC_W;
    localparam int OUT_W     = CLIP_W + $clog2(NCH);
    localparam int CLIP_MAX  = (1 << (CLIP_W - 1)) - 1;
    localparam int CLIP_MIN  = -(1 << (CLIP_W - 1));
    localparam int DAC_CH    = NCH - 1;

    typedef logic signed [IN_W-1:0]   raw_t;
    typedef logic signed [CLIP_W-1:0] clip_t;
    typedef logic signed [OUT_W-1:0]  acc_t;

    typedef struct packed {
        logic [NCH-1:0] left;
        logic [NCH-1:0] right;
    } pan_t;

    typedef struct packed {
        logic  on;
        clip_t pcm;
    } dsamp_t;

    typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

    // saturate a wide channel value into the per-channel range
    function automatic clip_t sat(input raw_t v);
        int iv;
        iv = int'(v);
        if (iv > CLIP_MAX)      return clip_t'(CLIP_MAX);
        else if (iv < CLIP_MIN) return clip_t'(CLIP_MIN);
        else                    return clip_t'(iv);
    endfunction

    // offset-binary byte to signed, scaled up to the channel width
    function automatic clip_t byte_to_pcm(input logic [DAC_W-1:0] b);
        return {~b[DAC_W-1], b[DAC_W-2:0], {DAC_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/mix_clip.sv
`timescale 1ns/1ps
module mix_clip
    import mix_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  raw_t  raw,
    output clip_t clipped
);
    always_comb clipped = sat(raw);

    // R1: out-of-range values land on the nearest limit
    p_clip_hi_r1: assert property (@(posedge clk) disable iff (rst)
        (int'(raw) > CLIP_MAX) |-> (int'(clipped) == CLIP_MAX));
    p_clip_lo_r1: assert property (@(posedge clk) disable iff (rst)
        (int'(raw) < CLIP_MIN) |-> (int'(clipped) == CLIP_MIN));
    // R2: in-range values pass unchanged
    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(raw) <= CLIP_MAX && int'(raw) >= CLIP_MIN) |-> (int'(clipped) == int'(raw)));
endmodule

// File: rtl/mix_cfg.sv
`timescale 1ns/1ps
module mix_cfg
    import mix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [NCH-1:0]   pan_l_in,
    input  logic [NCH-1:0]   pan_r_in,
    input  logic             dac_en_in,
    input  logic             dac_we,
    input  logic [DAC_W-1:0] dac_byte,
    output pan_t             pan,
    output dsamp_t           dsamp
);
    pan_t   pan_q;
    dsamp_t ds_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pan_q.left  <= '1;
            pan_q.right <= '1;
            ds_q.on     <= 1'b0;
            ds_q.pcm    <= '0;
        end else begin
            if (cfg_we) begin
                pan_q.left  <= pan_l_in;
                pan_q.right <= pan_r_in;
                ds_q.on     <= dac_en_in;
            end
            if (dac_we) begin
                ds_q.pcm <= byte_to_pcm(dac_byte);
            end
        end
    end

    assign pan   = pan_q;
    assign dsamp = ds_q;

    // R7: defaults right after reset
    p_cfg_reset_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pan.left == '1 && pan.right == '1 && !dsamp.on && dsamp.pcm == '0));
    // R6: byte load lands in the stored sample on the next cycle
    p_dac_load_r6: assert property (@(posedge clk) disable iff (rst)
        (dac_we && dac_byte == {DAC_W{1'b1}}) |=> (int'(dsamp.pcm) == ((1 << (DAC_W - 1)) - 1) * (1 << DAC_SHIFT)));
endmodule

// File: rtl/mix_bus.sv
`timescale 1ns/1ps
module mix_bus
    import mix_pkg::*;
#(
    parameter side_e SIDE = SIDE_L
) (
    input  clip_t          chans [NCH],
    input  logic [NCH-1:0] en,
    output acc_t           sum
);
    always_comb begin
        sum = '0;
        for (int i = 0; i < NCH; i++) begin
            if (en[i]) sum = sum + acc_t'(chans[i]);
        end
    end

    // side tag only names the instance; both sides share the adder
    if (SIDE != SIDE_L && SIDE != SIDE_R) begin : g_bad_side
        initial $error("mix_bus: unknown side");
    end
endmodule

// File: rtl/fm_stereo_mixer.sv
`timescale 1ns/1ps
module fm_stereo_mixer
    import mix_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [NCH*IN_W-1:0]   ch_sum,
    input  logic                  cfg_we,
    input  logic [NCH-1:0]        cfg_pan_l,
    input  logic [NCH-1:0]        cfg_pan_r,
    input  logic                  cfg_dac_en,
    input  logic                  dac_we,
    input  logic [DAC_W-1:0]      dac_byte,
    output logic                  out_valid,
    output logic signed [OUT_W-1:0] out_l,
    output logic signed [OUT_W-1:0] out_r
);
    pan_t   pan;
    dsamp_t dsamp;
    clip_t  clipped [NCH];
    clip_t  mixed   [NCH];
    acc_t   sum_l;
    acc_t   sum_r;

    mix_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .pan_l_in  (cfg_pan_l),
        .pan_r_in  (cfg_pan_r),
        .dac_en_in (cfg_dac_en),
        .dac_we    (dac_we),
        .dac_byte  (dac_byte),
        .pan       (pan),
        .dsamp     (dsamp)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mix_clip u_clip (
            .clk     (clk),
            .rst     (rst),
            .raw     (raw_t'(ch_sum[c*IN_W +: IN_W])),
            .clipped (clipped[c])
        );
        if (c == DAC_CH) begin : g_dsub
            assign mixed[c] = dsamp.on ? dsamp.pcm : clipped[c];
        end else begin : g_fm
            assign mixed[c] = clipped[c];
        end
    end

    mix_bus #(.SIDE(SIDE_L)) u_bus_l (.chans(mixed), .en(pan.left),  .sum(sum_l));
    mix_bus #(.SIDE(SIDE_R)) u_bus_r (.chans(mixed), .en(pan.right), .sum(sum_r));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_l     <= '0;
            out_r     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_l <= sum_l;
                out_r <= sum_r;
            end
        end
    end

    // R8: output strobe follows the input strobe by one cycle
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_l) && $stable(out_r)));
    // R3: an empty left mask yields a silent left output
    p_pan_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pan.left == '0) |=> (out_l == '0));
    // R6: with only the substituted channel panned, the stored sample is the output
    p_dac_sub_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dsamp.on && pan.left == NCH'(1 << DAC_CH)) |=> (out_l == $past(acc_t'(dsamp.pcm))));
    // R7: outputs cleared right after reset
    p_out_reset_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_l == '0 && out_r == '0));
endmodule

// File: tb/fm_stereo_mixer_test.sv
`timescale 1ns/1ps
module fm_stereo_mixer_test;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [107:0]      ch_sum = '0;
    logic              cfg_we = 1'b0;
    logic [5:0]        cfg_pan_l = '0;
    logic [5:0]        cfg_pan_r = '0;
    logic              cfg_dac_en = 1'b0;
    logic              dac_we = 1'b0;
    logic [7:0]        dac_byte = '0;
    logic              out_valid;
    logic signed [16:0] out_l;
    logic signed [16:0] out_r;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fm_stereo_mixer uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ch_sum(ch_sum),
        .cfg_we(cfg_we), .cfg_pan_l(cfg_pan_l), .cfg_pan_r(cfg_pan_r),
        .cfg_dac_en(cfg_dac_en), .dac_we(dac_we), .dac_byte(dac_byte),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
    );

    localparam int NV = 8;
    localparam int VEC_CH [NV][6] = '{
        '{8191, -8192, 8192, -8193, 0, 1},
        '{131071, -131072, 100, -100, 7, -7},
        '{1000, 2000, 3000, 4000, 5000, 6000},
        '{-5, -6, -7, -8, -9, -10},
        '{20000, 20000, 20000, 20000, 20000, 20000},
        '{-20000, -20000, -20000, -20000, -20000, -20000},
        '{8190, -8191, 9000, -9000, 1, -1},
        '{0, 0, 0, 0, 0, 131071}
    };
    localparam logic [5:0] VEC_PL [NV] = '{6'h3F, 6'h01, 6'h15, 6'h00, 6'h3F, 6'h3F, 6'h0C, 6'h20};
    localparam logic [5:0] VEC_PR [NV] = '{6'h3F, 6'h02, 6'h2A, 6'h3F, 6'h00, 6'h3F, 6'h30, 6'h20};
    localparam int VEC_EL [NV] = '{-1, 8191, 9000, 0, 49146, -49152, -1, 8191};
    localparam int VEC_ER [NV] = '{-1, -8192, 12000, -45, 0, -49152, 0, 8191};
    localparam string VEC_REQ [NV] = '{"R1/R2/R4", "R1/R3", "R2/R4", "R3/R4",
                                       "R1/R5", "R1/R5", "R1/R2/R4", "R1/R4"};

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [5:0] pl, input logic [5:0] pr, input logic den);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pan_l = pl; cfg_pan_r = pr; cfg_dac_en = den;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_byte(input logic [7:0] b);
        @(negedge clk);
        dac_we = 1'b1; dac_byte = b;
        @(negedge clk);
        dac_we = 1'b0;
    endtask

    task automatic load_all(input int v0, input int v1, input int v2,
                            input int v3, input int v4, input int v5);
        ch_sum[0*18 +: 18] = 18'(v0);
        ch_sum[1*18 +: 18] = 18'(v1);
        ch_sum[2*18 +: 18] = 18'(v2);
        ch_sum[3*18 +: 18] = 18'(v3);
        ch_sum[4*18 +: 18] = 18'(v4);
        ch_sum[5*18 +: 18] = 18'(v5);
    endtask

    // strobe one sample; returns after the output register has loaded
    task automatic send(input string req);
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " out_valid"}, int'(out_valid), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state of the outputs
        chk("R7 out_valid after reset", int'(out_valid), 0);
        chk("R7 out_l after reset", int'(out_l), 0);
        chk("R7 out_r after reset", int'(out_r), 0);
        // R7: default pan both sides, channel 5 input used
        load_all(100, 100, 100, 100, 100, 100);
        send("R7");
        chk("R7 default pan left", int'(out_l), 600);
        chk("R7 default pan right", int'(out_r), 600);

        // table of vectors
        for (int v = 0; v < NV; v++) begin
            set_cfg(VEC_PL[v], VEC_PR[v], 1'b0);
            load_all(VEC_CH[v][0], VEC_CH[v][1], VEC_CH[v][2],
                     VEC_CH[v][3], VEC_CH[v][4], VEC_CH[v][5]);
            send(VEC_REQ[v]);
            chk({VEC_REQ[v], " left"}, int'(out_l), VEC_EL[v]);
            chk({VEC_REQ[v], " right"}, int'(out_r), VEC_ER[v]);
        end

        // R6: direct-sample substitution on channel 5
        set_cfg(6'h20, 6'h20, 1'b1);
        set_byte(8'hFF);
        load_all(0, 0, 0, 0, 0, 5000);
        send("R6");
        chk("R6 byte FF left", int'(out_l), 8128);
        chk("R6 byte FF right", int'(out_r), 8128);
        set_byte(8'h00);
        send("R6");
        chk("R6 byte 00", int'(out_l), -8192);
        set_byte(8'h80);
        send("R6");
        chk("R6 byte 80", int'(out_r), 0);
        set_cfg(6'h20, 6'h20, 1'b0);
        send("R6");
        chk("R6 mode off restores input", int'(out_l), 5000);

        // R8: idle cycles hold outputs and keep out_valid low
        repeat (3) @(negedge clk);
        chk("R8 out_valid idle", int'(out_valid), 0);
        load_all(1, 1, 1, 1, 1, 1);
        @(negedge clk);
        chk("R8 out_l hold", int'(out_l), 5000);
        chk("R8 out_r hold", int'(out_r), 5000);

        // R7: reset after a non-default configuration
        set_cfg(6'h00, 6'h00, 1'b1);
        set_byte(8'hFF);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R7 out_l after re-reset", int'(out_l), 0);
        chk("R7 out_valid after re-reset", int'(out_valid), 0);
        load_all(100, 100, 100, 100, 100, 100);
        send("R7");
        chk("R7 pans restored left", int'(out_l), 600);
        chk("R7 pans restored right", int'(out_r), 600);
        set_cfg(6'h3F, 6'h3F, 1'b1);
        send("R7");
        chk("R7 stored sample zero", int'(out_l), 500);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule